// File: doc/BRIEF.md
# Serial avionics word transmitter

This block sends 32-bit avionics data words over a two-wire bipolar return-to-zero line. The line is shown in digital form as a "one" output and a "zero" output. A host writes each word over a 16-bit bus in two halves, and each half has its own strobe. A completed word joins a 32-entry first-in first-out queue. While the transmit enable input is high, the block takes words from the head of the queue and sends them one bit cell at a time. Bit 1 goes first. Consecutive words are separated by a fixed stretch of null time.

The length of a bit cell is the master clock divided by one of two ratios, fast (10) or slow (80). A rate select input picks the ratio. Bit 32 of each word is either the host's own data bit or an odd-parity bit that the block generates over bits 1 to 31. Three queue flags are visible to the host: ready (queue empty), half full and full. An asynchronous active-low reset returns the block to an empty, quiet state.

Top module: `arinc_word_tx`

## Requirements
- R1: A pulse on `load_low` stores `host_data` as word bits 1 to 16, with bus bit i becoming word bit i+1. A later pulse on `load_high` supplies word bits 17 to 32 and queues the completed word on that same clock edge. A `load_high` pulse that has no stored low half since the last queued word does nothing.
- R2: The queue holds 32 words and sends them in the order they were loaded. A word that completes while the queue is full (and no word leaves the queue on that edge) is discarded.
- R3: After each clock edge the flags reflect the queue count. `tx_ready` is 1 exactly when the count is 0. `fifo_half` is 1 when the count is 16 or more. `fifo_full` is 1 when the count is 32.
- R4: A word starts only on an edge where the block is idle, `tx_enable` is 1 and the queue is not empty. That word leaves the queue on the same edge, and line activity begins right after it. While `tx_enable` is 0, no word starts. If `tx_enable` drops in the middle of a word, that word still completes.
- R5: Each bit cell lasts D master clocks. D is 10 when `rate_slow` is 0 and 80 when it is 1. The value of `rate_slow` is sampled when the word starts.
- R6: Within a bit cell, either `line_one` (for a 1) or `line_zero` (for a 0) is high for the first D/2 clocks, and both are low for the second D/2 clocks. Bits go out in the order word bit 1 (the low half's bus bit 0) through word bit 32 (the high half's bus bit 15).
- R7: When `bit32_parity` is 0, bit 32 is the host's data bit. When it is 1, bit 32 is set so that bits 1 to 32 together contain an odd number of ones. The value of `bit32_parity` is sampled when the word starts.
- R8: After the bit-32 cell, both lines stay low for 4·D clocks, followed by one more idle clock. Words that are queued back to back therefore start exactly 36·D+1 clocks apart.
- R9: Driving `rst_n` low at any time does the following: it empties the queue, drops any stored low half, abandons a word in flight, forces both lines low, sets `tx_ready` to 1 and clears `fifo_half` and `fifo_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_data | input | 16 | Half-word from the host |
| load_low | input | 1 | Strobe that stores the low half (bits 1 to 16) |
| load_high | input | 1 | Strobe that supplies the high half (bits 17 to 32) and queues the word |
| rate_slow | input | 1 | 0: cell of 10 clocks, 1: cell of 80 clocks |
| bit32_parity | input | 1 | 1: bit 32 is generated odd parity, 0: bit 32 is host data |
| tx_enable | input | 1 | Allows new words to start |
| line_one | output | 1 | High during the first half of a cell that carries a 1 |
| line_zero | output | 1 | High during the first half of a cell that carries a 0 |
| tx_ready | output | 1 | Queue is empty |
| fifo_half | output | 1 | Queue holds 16 or more words |
| fifo_full | output | 1 | Queue holds 32 words |

## Verification
The bench aims at the edges of the two-strobe load:
- a high half with no low half before it, which a careless design would turn into a spurious word;
- a word pushed into a full queue, which a wrong design would let overwrite the oldest entry or corrupt the count.

It changes the rate select and the parity select in the middle of a word, and it drops the enable in the middle of a word. A design that re-reads these inputs would stretch or truncate cells, alter bit 32 or cut a word short. It measures the spacing between back-to-back words, where a design with an off-by-one in the null count would be caught. It also resets the block in the middle of a word while a low half is pending, where a design that keeps the stale half would queue a garbage word on the next high strobe.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_GAP  = 2'd2
  } tx_state_e;

  // Last count value inside one bit cell for the selected rate.
  function automatic int unsigned cell_last(input logic slow,
                                            input int unsigned fast_div,
                                            input int unsigned slow_div);
    return (slow ? slow_div : fast_div) - 1;
  endfunction

  // First count value that belongs to the null half of a bit cell.
  function automatic int unsigned cell_mid(input logic slow,
                                           input int unsigned fast_div,
                                           input int unsigned slow_div);
    return (slow ? slow_div : fast_div) / 2;
  endfunction

endpackage

// File: rtl/arinc_tx_loader.sv
module arinc_tx_loader #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W-1:0]   host_data,
  input  logic                lo_wr,
  input  logic                hi_wr,
  output logic                push,
  output logic [2*HALF_W-1:0] push_word
);

  logic [HALF_W-1:0] lo_q;
  logic              lo_have;

  // A word is complete only when a low half is waiting.
  assign push      = hi_wr & lo_have;
  assign push_word = {host_data, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      lo_have <= 1'b0;
    end else begin
      if (lo_wr) begin
        lo_q    <= host_data;
        lo_have <= 1'b1;
      end else if (push) begin
        lo_have <= 1'b0;
      end
    end
  end

  AST_PAIR_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !lo_wr) |=> !lo_have) else $error("low half reused"); // R1

endmodule

// File: rtl/arinc_tx_fifo.sv
module arinc_tx_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             half,
  output logic             full
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             accept, take;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign accept = push & ~full;
  assign take   = pop & ~empty;
  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign half   = (count >= CNT_W'(DEPTH / 2));
  assign head   = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= ptr_step(wr_ptr);
      if (take)   rd_ptr <= ptr_step(rd_ptr);
      case ({accept, take})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("pop from empty queue"); // R4

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && $stable(count))) else $error("full queue grew"); // R2

endmodule

// File: rtl/arinc_tx_cell_timer.sv
module arinc_tx_cell_timer
  import arinc_tx_pkg::*;
#(
  parameter int unsigned FAST_DIV = 10,
  parameter int unsigned SLOW_DIV = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slow_in,
  input  logic run,
  output logic first_half,
  output logic bit_end
);

  localparam int unsigned MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);

  logic             slow_q;
  logic [CNT_W-1:0] cnt, last, mid;

  assign last       = CNT_W'(cell_last(slow_q, FAST_DIV, SLOW_DIV));
  assign mid        = CNT_W'(cell_mid(slow_q, FAST_DIV, SLOW_DIV));
  assign bit_end    = run && (cnt == last);
  assign first_half = (cnt < mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      slow_q <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      slow_q <= slow_in;
    end else if (run) begin
      cnt <= bit_end ? '0 : cnt + CNT_W'(1);
    end
  end

  AST_CELL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !restart) |=> (cnt == '0)) else $error("cell did not wrap"); // R5

endmodule

// File: rtl/arinc_tx_serializer.sv
module arinc_tx_serializer
  import arinc_tx_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              parity_sel,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] head,
  input  logic              first_half,
  input  logic              bit_end,
  output logic              pop,
  output logic              timer_restart,
  output logic              timer_run,
  output logic              line_one,
  output logic              line_zero,
  output logic              word_start,
  output logic              word_done
);

  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned GAP_W = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1;

  tx_state_e         state;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] sealed;
  logic [BIT_W-1:0]  bit_idx;
  logic [GAP_W-1:0]  gap_idx;
  logic              gap_done;
  logic              busy;

  // Bit 32 is either host data or odd parity over the lower bits.
  always_comb begin
    sealed = head;
    if (parity_sel) sealed[WORD_W-1] = ~(^head[WORD_W-2:0]);
  end

  assign busy          = (state != TX_IDLE);
  assign word_start    = (state == TX_IDLE) && tx_enable && !fifo_empty;
  assign pop           = word_start;
  assign timer_restart = word_start;
  assign timer_run     = busy;
  assign word_done     = (state == TX_SEND) && bit_end && (bit_idx == BIT_W'(WORD_W - 1));
  assign gap_done      = (state == TX_GAP) && bit_end && (gap_idx == GAP_W'(GAP_BITS - 1));
  assign line_one      = (state == TX_SEND) && first_half && shreg[0];
  assign line_zero     = (state == TX_SEND) && first_half && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      gap_idx <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (word_start) begin
            state   <= TX_SEND;
            shreg   <= sealed;
            bit_idx <= '0;
          end
        end
        TX_SEND: begin
          if (word_done) begin
            state   <= TX_GAP;
            gap_idx <= '0;
          end else if (bit_end) begin
            bit_idx <= bit_idx + BIT_W'(1);
            shreg   <= shreg >> 1;
          end
        end
        TX_GAP: begin
          if (gap_done)     state   <= TX_IDLE;
          else if (bit_end) gap_idx <= gap_idx + GAP_W'(1);
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_enable)) else $error("word started while disabled"); // R4

  AST_NULL_AT_CELL_END: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> (!line_one && !line_zero)) else $error("line high in null half"); // R6

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (!line_one && !line_zero && busy)) else $error("gap not quiet"); // R8

endmodule

// File: rtl/arinc_word_tx.sv
module arinc_word_tx #(
  parameter int unsigned HALF_W     = 16,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned FAST_DIV   = 10,
  parameter int unsigned SLOW_DIV   = 80,
  parameter int unsigned GAP_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] host_data,
  input  logic              load_low,
  input  logic              load_high,
  input  logic              rate_slow,
  input  logic              bit32_parity,
  input  logic              tx_enable,
  output logic              line_one,
  output logic              line_zero,
  output logic              tx_ready,
  output logic              fifo_half,
  output logic              fifo_full
);

  localparam int unsigned WORD_W = 2 * HALF_W;

  logic              push, pop, empty_w;
  logic [WORD_W-1:0] push_word, head_word;
  logic              first_half, bit_end;
  logic              timer_restart, timer_run;
  logic              word_start, word_done;

  arinc_tx_loader #(.HALF_W(HALF_W)) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_data (host_data),
    .lo_wr     (load_low),
    .hi_wr     (load_high),
    .push      (push),
    .push_word (push_word)
  );

  arinc_tx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .wr_data (push_word),
    .pop     (pop),
    .head    (head_word),
    .empty   (empty_w),
    .half    (fifo_half),
    .full    (fifo_full)
  );

  arinc_tx_cell_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (timer_restart),
    .slow_in    (rate_slow),
    .run        (timer_run),
    .first_half (first_half),
    .bit_end    (bit_end)
  );

  arinc_tx_serializer #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) u_ser (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_enable     (tx_enable),
    .parity_sel    (bit32_parity),
    .fifo_empty    (empty_w),
    .head          (head_word),
    .first_half    (first_half),
    .bit_end       (bit_end),
    .pop           (pop),
    .timer_restart (timer_restart),
    .timer_run     (timer_run),
    .line_one      (line_one),
    .line_zero     (line_zero),
    .word_start    (word_start),
    .word_done     (word_done)
  );

  assign tx_ready = empty_w;

  AST_STRICT_ALTERNATION: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> !line_one && !line_zero) else $error("start while lines busy"); // R8

endmodule

// File: tb/tb_arinc_word_tx.sv
module tb_arinc_word_tx;

  localparam int FAST = 10;
  localparam int SLOW = 80;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b1;
  logic [15:0] host_data = '0;
  logic        load_low = 1'b0, load_high = 1'b0;
  logic        rate_slow = 1'b0, bit32_parity = 1'b0, tx_enable = 1'b0;
  wire         line_one, line_zero, tx_ready, fifo_half, fifo_full;

  arinc_word_tx dut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .load_low(load_low),
    .load_high(load_high), .rate_slow(rate_slow), .bit32_parity(bit32_parity),
    .tx_enable(tx_enable), .line_one(line_one), .line_zero(line_zero),
    .tx_ready(tx_ready), .fifo_half(fifo_half), .fifo_full(fifo_full)
  );

  int    compared = 0, mismatched = 0, cyc = 0;
  string phase_tag = "R9";

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_q [$];
  logic [1:0]  m_stream [$];
  logic [15:0] m_lo;
  bit          m_lo_have;
  logic [1:0]  exp_lines = 2'b00;
  int          m_pre, m_d;
  logic [31:0] m_w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_stream.delete();
      m_lo_have = 1'b0;
      exp_lines = 2'b00;
    end else begin
      m_pre = m_q.size();
      if (m_stream.size() == 0 && tx_enable && m_pre > 0) begin
        m_w = m_q.pop_front();
        if (bit32_parity) m_w[31] = ~(^m_w[30:0]);
        m_d = rate_slow ? SLOW : FAST;
        for (int b = 0; b < 32; b++)
          for (int c = 0; c < m_d; c++)
            m_stream.push_back((c < m_d / 2) ? (m_w[b] ? 2'b10 : 2'b01) : 2'b00);
        for (int g = 0; g < 4 * m_d + 1; g++) m_stream.push_back(2'b00);
      end
      if (load_high && m_lo_have) begin
        if (m_pre < 32) m_q.push_back({host_data, m_lo});
        m_lo_have = 1'b0;
      end
      if (load_low) begin
        m_lo      = host_data;
        m_lo_have = 1'b1;
      end
      exp_lines = (m_stream.size() > 0) ? m_stream.pop_front() : 2'b00;
    end
  end

  // ---------------- per-cycle comparison and line decoder ----------------
  int          hi_samples = 0, dec_n = 0, m_sz;
  bit          prev_act = 1'b0, act;
  logic [31:0] dec_w;
  logic [31:0] dec_q [$];
  int          starts [$];
  logic [2:0]  exp_flags;

  always @(negedge clk) begin
    m_sz      = m_q.size();
    exp_flags = {m_sz == 0, m_sz >= 16, m_sz == 32};
    compared++;
    if ({line_one, line_zero} !== exp_lines) begin
      mismatched++;
      $display("FAIL %s lines at cycle %0d: actual %b expected %b",
               phase_tag, cyc, {line_one, line_zero}, exp_lines);
    end
    compared++;
    if ({tx_ready, fifo_half, fifo_full} !== exp_flags) begin
      mismatched++;
      $display("FAIL R3 flags at cycle %0d: actual %b expected %b",
               cyc, {tx_ready, fifo_half, fifo_full}, exp_flags);
    end
    if (!rst_n) begin
      dec_n    = 0;
      prev_act = 1'b0;
    end else begin
      act = line_one | line_zero;
      if (act) hi_samples++;
      if (act && !prev_act) begin
        if (dec_n == 0) starts.push_back(cyc);
        dec_w[dec_n] = line_one;
        dec_n++;
        if (dec_n == 32) begin
          dec_q.push_back(dec_w);
          dec_n = 0;
        end
      end
      prev_act = act;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      mismatched++;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
    compared++;
    if (actual !== expected) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, actual, expected);
    end
  endtask

  task automatic load_word(input logic [31:0] w);
    host_data = w[15:0];
    load_low  = 1'b1;
    tick(1);
    load_low  = 1'b0;
    host_data = w[31:16];
    load_high = 1'b1;
    tick(1);
    load_high = 1'b0;
  endtask

  task automatic wait_drain();
    do @(negedge clk); while (m_q.size() != 0 || m_stream.size() != 0);
    tick(2);
  endtask

  function automatic logic [31:0] seal(input logic [31:0] w);
    int ones = 0;
    for (int i = 0; i < 31; i++) ones += w[i];
    return {(ones % 2 == 0), w[30:0]};
  endfunction

  logic [31:0] words [$];

  initial begin
    #1 rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R9: state after reset
    check("R9", "ready after reset", tx_ready, 1);
    check("R9", "half after reset", fifo_half, 0);
    check("R9", "full after reset", fifo_full, 0);

    // R1: high half alone is ignored
    phase_tag = "R1";
    host_data = 16'hBEEF;
    load_high = 1'b1;
    tick(1);
    load_high = 1'b0;
    tick(2);
    check("R1", "lone high half queued nothing", tx_ready, 1);

    // R4: disabled transmitter holds words
    phase_tag = "R4";
    words = '{32'h8000_0001, 32'h5555_AAAA, 32'h0F0F_F0F0};
    hi_samples = 0;
    foreach (words[i]) load_word(words[i]);
    tick(100);
    check("R4", "no line activity while disabled", hi_samples, 0);
    check("R4", "words kept while disabled", tx_ready, 0);

    // R6 / R8: order of bits and spacing of words
    phase_tag = "R6";
    dec_q.delete();
    starts.delete();
    tx_enable = 1'b1;
    wait_drain();
    tx_enable = 1'b0;
    check("R6", "decoded word count", dec_q.size(), 3);
    for (int i = 0; i < 3 && i < dec_q.size(); i++)
      check("R6", "decoded word", dec_q[i], words[i]);
    if (starts.size() == 3) begin
      check("R8", "start spacing 1", starts[1] - starts[0], 36 * FAST + 1);
      check("R8", "start spacing 2", starts[2] - starts[1], 36 * FAST + 1);
    end else check("R8", "start stamps", starts.size(), 3);
    check("R5", "fast high samples", hi_samples, 3 * 32 * FAST / 2);

    // R7: generated parity
    phase_tag = "R7";
    bit32_parity = 1'b1;
    words = '{32'h0000_0000, 32'h8000_0001, 32'h7FFF_FFFF, 32'h1234_5678};
    dec_q.delete();
    foreach (words[i]) load_word(words[i]);
    tx_enable = 1'b1;
    wait_drain();
    tx_enable = 1'b0;
    check("R7", "parity word count", dec_q.size(), 4);
    for (int i = 0; i < 4 && i < dec_q.size(); i++) begin
      check("R7", "sealed word", dec_q[i], seal(words[i]));
      check("R7", "odd ones", $countones(dec_q[i]) % 2, 1);
    end

    // R5: slow rate, selects changed mid-word must not matter
    phase_tag = "R5";
    bit32_parity = 1'b0;
    rate_slow    = 1'b1;
    dec_q.delete();
    load_word(32'hA5A5_5A5A);
    hi_samples = 0;
    tx_enable  = 1'b1;
    tick(30);
    rate_slow    = 1'b0;
    bit32_parity = 1'b1;
    wait_drain();
    tx_enable    = 1'b0;
    bit32_parity = 1'b0;
    check("R5", "slow high samples", hi_samples, 32 * SLOW / 2);
    check("R7", "parity select sampled at start", dec_q.size() > 0 ? dec_q[0] : 0, 32'hA5A5_5A5A);

    // R3 / R2: fill past full
    phase_tag = "R3";
    words.delete();
    for (int i = 0; i < 33; i++) begin
      words.push_back((i * 32'h0101_0103) ^ 32'h1357_9BDF);
      load_word(words[i]);
      if (i == 14) check("R3", "half clear at 15", fifo_half, 0);
      if (i == 15) check("R3", "half set at 16", fifo_half, 1);
      if (i == 30) check("R3", "full clear at 31", fifo_full, 0);
      if (i == 31) check("R3", "full set at 32", fifo_full, 1);
      if (i == 32) check("R2", "still full after drop", fifo_full, 1);
    end
    phase_tag = "R2";
    dec_q.delete();
    tx_enable = 1'b1;
    wait_drain();
    tx_enable = 1'b0;
    check("R2", "drained count", dec_q.size(), 32);
    for (int i = 0; i < 32 && i < dec_q.size(); i++)
      check("R2", "queue order", dec_q[i], words[i]);

    // R4: enable dropped mid-word
    phase_tag = "R4";
    dec_q.delete();
    load_word(32'h1234_5678);
    tx_enable = 1'b1;
    tick(50);
    tx_enable = 1'b0;
    wait_drain();
    check("R4", "word completes after enable drop", dec_q.size(), 1);
    check("R4", "completed word", dec_q.size() > 0 ? dec_q[0] : 0, 32'h1234_5678);

    // R9: reset mid-word with a pending low half
    phase_tag = "R9";
    load_word(32'hCAFE_0001);
    load_word(32'hCAFE_0002);
    tx_enable = 1'b1;
    tick(100);
    host_data = 16'h1111;
    load_low  = 1'b1;
    tick(1);
    load_low  = 1'b0;
    rst_n     = 1'b0;
    tick(2);
    check("R9", "lines low in reset", {line_one, line_zero}, 0);
    rst_n = 1'b1;
    tick(1);
    check("R9", "ready after mid-word reset", tx_ready, 1);
    check("R9", "half after mid-word reset", fifo_half, 0);
    hi_samples = 0;
    tick(400);
    check("R9", "no activity after reset", hi_samples, 0);
    host_data = 16'h2222;
    load_high = 1'b1;
    tick(1);
    load_high = 1'b0;
    tick(2);
    check("R9", "pending low half dropped", tx_ready, 1);
    tx_enable = 1'b0;
    tick(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule